// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block is the transmit half of a synchronous serial port. Software-side logic writes 32-bit values through a single write strobe. Each accepted write becomes two 16-bit words in a paired FIFO of 30 entries. The low half goes in first and the high half second. A 16-bit shift register takes one word from the FIFO each time a frame sync is seen. It then sends that word on the serial data line, one bit per active edge of the serial clock.

The serial clock and the frame sync come from outside the system clock domain. Both are synchronized into the system clock. The selected clock line is edge-detected on the configured edge, either rising or falling, and this produces a one-cycle shift enable. Configuration inputs select which of two clock lines drives the transmitter: a general-purpose clock pin or the receive clock. They also select which edge is active and whether the word leaves MSB-first or LSB-first. The block reports FIFO occupancy, a full flag that refuses further writes, and a sticky underrun flag.

Top module: `bstx_top`

## Requirements
- R1: Synchronous active-high reset clears fifo_level to 0 and drives full_flag, underrun_flag and ser_out to 0.
- R2: An accepted write of wr_data stores two words. wr_data[15:0] is transmitted in the frame before wr_data[31:16].
- R3: A write is refused, leaving fifo_level unchanged, when fewer than two entries are free. full_flag is 1 exactly when fifo_level is 29 or 30.
- R4: With cfg_lsb_first = 0, bit 15 of a word is sent first and bit 0 last.
- R5: With cfg_lsb_first = 1, bit 0 of a word is sent first and bit 15 last.
- R6: cfg_edge_fall = 0 makes the rising edge of the serial clock active. cfg_edge_fall = 1 makes the falling edge active. Each active edge advances ser_out by one bit.
- R7: cfg_clk_src = 0 selects gp_clk and cfg_clk_src = 1 selects rx_clk. Edges and frame syncs seen while only the unselected clock toggles change neither ser_out nor fifo_level.
- R8: An active edge with fsync_in high loads the next FIFO word and lowers fifo_level by one. After 16 bits, further active edges without a frame sync drive ser_out to 0.
- R9: A frame sync while the FIFO is empty sends an all-zero word and sets underrun_flag. The flag stays set until reset.
- R10: fifo_level equals the number of stored words not yet loaded, from 0 to 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per 32-bit write |
| wr_data | input | 32 | Write data; low half queued first |
| cfg_clk_src | input | 1 | 0: gp_clk, 1: rx_clk drives the transmitter |
| cfg_edge_fall | input | 1 | 0: rising edge active, 1: falling edge active |
| cfg_lsb_first | input | 1 | 0: MSB first, 1: LSB first |
| gp_clk | input | 1 | General-purpose serial clock pin |
| rx_clk | input | 1 | Receive-side serial clock |
| fsync_in | input | 1 | Frame sync, sampled on the active edge |
| ser_out | output | 1 | Serial data out |
| fifo_level | output | 5 | Words held in the FIFO |
| full_flag | output | 1 | Fewer than two entries free |
| underrun_flag | output | 1 | Sticky: a frame started with an empty FIFO |

## Verification
The hardest state to reach is an odd FIFO level at the top of the range. With 29 words held, a single free slot is still not enough for a write. Reaching it takes fifteen back-to-back writes, a refused sixteenth write, and then exactly one full serial frame to remove one word. A second write is tried at that point, and only after another frame does a write succeed. A scoreboard of expected words, built from the accepted writes only, then confirms that no refused data ever reaches the serial line while all 30 words drain.

// File: rtl/bstx_pkg.sv
package bstx_pkg;

  typedef enum logic {
    CLK_SRC_GPIO = 1'b0,
    CLK_SRC_RX   = 1'b1
  } clk_src_e;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } clk_edge_e;

endpackage

// File: rtl/bstx_sync.sv
module bstx_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/bstx_tick.sv
module bstx_tick
  import bstx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_clk_src,
  input  logic cfg_edge_fall,
  input  logic gp_clk,
  input  logic rx_clk,
  input  logic fsync_in,
  output logic tick,
  output logic fs_smp
);

  clk_src_e  src;
  clk_edge_e edg;
  logic      raw_clk;
  logic [1:0] synced;
  logic      clk_prev;
  logic      rise, fall;

  assign src = clk_src_e'(cfg_clk_src);
  assign edg = clk_edge_e'(cfg_edge_fall);
  assign raw_clk = (src == CLK_SRC_RX) ? rx_clk : gp_clk;

  // frame sync travels with the clock so both see equal latency
  bstx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({fsync_in, raw_clk}),
    .q   (synced)
  );

  always_ff @(posedge clk) begin
    if (rst) clk_prev <= 1'b0;
    else     clk_prev <= synced[0];
  end

  assign rise   = synced[0] & ~clk_prev;
  assign fall   = ~synced[0] & clk_prev;
  assign tick   = (edg == EDGE_FALL) ? fall : rise;
  assign fs_smp = synced[1];

endmodule

// File: rtl/bstx_fifo.sv
module bstx_fifo #(
  parameter  int W       = 16,
  parameter  int DEPTH   = 30,
  localparam int LEVEL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [2*W-1:0]     push_data,
  input  logic               pop,
  output logic [W-1:0]       head,
  output logic               empty,
  output logic [LEVEL_W-1:0] level,
  output logic               full_flag
);

  localparam int PAIRS = DEPTH / 2;
  localparam int RD_W  = $clog2(DEPTH);
  localparam int PR_W  = RD_W - 1;

  // two single-port banks: low halves and high halves of each write
  logic [W-1:0] bank_lo [PAIRS];
  logic [W-1:0] bank_hi [PAIRS];

  logic [PR_W-1:0]    wr_pair;
  logic [RD_W-1:0]    rd_idx;
  logic [PR_W-1:0]    rd_pair;
  logic               accept;
  logic               pop_ok;
  logic [LEVEL_W-1:0] level_nxt;

  assign accept  = push && (level <= LEVEL_W'(DEPTH - 2));
  assign pop_ok  = pop && (level != '0);
  assign rd_pair = rd_idx[RD_W-1:1];
  assign empty   = (level == '0);
  assign head    = rd_idx[0] ? bank_hi[rd_pair] : bank_lo[rd_pair];

  assign level_nxt = level + (accept ? LEVEL_W'(2) : LEVEL_W'(0))
                           - (pop_ok ? LEVEL_W'(1) : LEVEL_W'(0));

  always_ff @(posedge clk) begin
    if (accept) begin
      bank_lo[wr_pair] <= push_data[W-1:0];
      bank_hi[wr_pair] <= push_data[2*W-1:W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pair   <= '0;
      rd_idx    <= '0;
      level     <= '0;
      full_flag <= 1'b0;
    end else begin
      if (accept)
        wr_pair <= (wr_pair == PR_W'(PAIRS - 1)) ? '0 : wr_pair + PR_W'(1);
      if (pop_ok)
        rd_idx <= (rd_idx == RD_W'(DEPTH - 1)) ? '0 : rd_idx + RD_W'(1);
      level     <= level_nxt;
      full_flag <= (level_nxt > LEVEL_W'(DEPTH - 2));
    end
  end

endmodule

// File: rtl/bstx_shift.sv
module bstx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         fs_smp,
  input  logic         cfg_lsb_first,
  input  logic         fifo_empty,
  input  logic [W-1:0] head,
  output logic         pop,
  output logic         ser_out,
  output logic         underrun_flag
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh;
  logic [CW-1:0] left;
  logic          lsb_q;
  logic          load;
  logic [W-1:0]  word;

  assign load = tick && fs_smp;
  assign pop  = load && !fifo_empty;
  assign word = fifo_empty ? '0 : head;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh            <= '0;
      left          <= '0;
      lsb_q         <= 1'b0;
      ser_out       <= 1'b0;
      underrun_flag <= 1'b0;
    end else if (load) begin
      lsb_q   <= cfg_lsb_first;
      ser_out <= cfg_lsb_first ? word[0] : word[W-1];
      sh      <= cfg_lsb_first ? (word >> 1) : (word << 1);
      left    <= CW'(W - 1);
      if (fifo_empty) underrun_flag <= 1'b1;
    end else if (tick) begin
      if (left != '0) begin
        ser_out <= lsb_q ? sh[0] : sh[W-1];
        sh      <= lsb_q ? (sh >> 1) : (sh << 1);
        left    <= left - CW'(1);
      end else begin
        ser_out <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bstx_top.sv
module bstx_top #(
  parameter  int WORD_W      = 16,
  parameter  int FIFO_DEPTH  = 30,
  parameter  int SYNC_STAGES = 2,
  localparam int LEVEL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [2*WORD_W-1:0] wr_data,
  input  logic                cfg_clk_src,
  input  logic                cfg_edge_fall,
  input  logic                cfg_lsb_first,
  input  logic                gp_clk,
  input  logic                rx_clk,
  input  logic                fsync_in,
  output logic                ser_out,
  output logic [LEVEL_W-1:0]  fifo_level,
  output logic                full_flag,
  output logic                underrun_flag
);

  logic              tick;
  logic              fs_smp;
  logic              pop;
  logic              empty;
  logic [WORD_W-1:0] head;

  bstx_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk           (clk),
    .rst           (rst),
    .cfg_clk_src   (cfg_clk_src),
    .cfg_edge_fall (cfg_edge_fall),
    .gp_clk        (gp_clk),
    .rx_clk        (rx_clk),
    .fsync_in      (fsync_in),
    .tick          (tick),
    .fs_smp        (fs_smp)
  );

  bstx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (wr_en),
    .push_data (wr_data),
    .pop       (pop),
    .head      (head),
    .empty     (empty),
    .level     (fifo_level),
    .full_flag (full_flag)
  );

  bstx_shift #(.W(WORD_W)) u_shift (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .fs_smp        (fs_smp),
    .cfg_lsb_first (cfg_lsb_first),
    .fifo_empty    (empty),
    .head          (head),
    .pop           (pop),
    .ser_out       (ser_out),
    .underrun_flag (underrun_flag)
  );

endmodule

// File: rtl/bstx_chk.sv
module bstx_chk #(
  parameter  int DEPTH = 30,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [LW-1:0] fifo_level,
  input logic          full_flag,
  input logic          underrun_flag,
  input logic          ser_out
);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (fifo_level == '0 && !full_flag && !underrun_flag && !ser_out));

  p_push_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && fifo_level <= LW'(DEPTH - 2)) |=> (fifo_level >= $past(fifo_level) + LW'(1)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && fifo_level >= LW'(DEPTH - 1)) |=> (fifo_level <= $past(fifo_level)));

  p_full_r3: assert property (@(posedge clk) disable iff (rst)
    full_flag == (fifo_level >= LW'(DEPTH - 1)));

  p_single_pop_r8: assert property (@(posedge clk) disable iff (rst)
    (fifo_level < $past(fifo_level)) |-> (fifo_level + LW'(1) == $past(fifo_level)));

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    underrun_flag |=> underrun_flag);

  p_level_bound_r10: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LW'(DEPTH));

endmodule

bind bstx_top bstx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .fifo_level    (fifo_level),
  .full_flag     (full_flag),
  .underrun_flag (underrun_flag),
  .ser_out       (ser_out)
);

// File: tb/bstx_top_test.sv
module bstx_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int DEPTH      = 30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        cfg_clk_src = 1'b0;
  logic        cfg_edge_fall = 1'b0;
  logic        cfg_lsb_first = 1'b0;
  logic        gp_clk = 1'b0;
  logic        rx_clk = 1'b0;
  logic        fsync_in = 1'b0;
  logic        ser_out;
  logic [4:0]  fifo_level;
  logic        full_flag;
  logic        underrun_flag;

  int          checks = 0;
  int          fails = 0;
  int          model_level = 0;
  bit          use_rx = 1'b0;
  bit          done = 1'b0;
  string       cur_req = "R2";
  logic [15:0] exp_q[$];
  logic [15:0] rx_word;
  event        word_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  bstx_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_clk_src(cfg_clk_src), .cfg_edge_fall(cfg_edge_fall),
    .cfg_lsb_first(cfg_lsb_first), .gp_clk(gp_clk), .rx_clk(rx_clk),
    .fsync_in(fsync_in), .ser_out(ser_out), .fifo_level(fifo_level),
    .full_flag(full_flag), .underrun_flag(underrun_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // driver: writes and records the words the port must send
  task automatic write32(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    if (model_level <= DEPTH - 2) begin
      exp_q.push_back(d[15:0]);
      exp_q.push_back(d[31:16]);
      model_level += 2;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_line(input logic v);
    if (use_rx) rx_clk = v; else gp_clk = v;
  endtask

  task automatic period(input bit fs, output logic b);
    fsync_in = fs;
    set_line(cfg_edge_fall ? 1'b1 : 1'b0);
    repeat (HALF) @(negedge clk);
    set_line(cfg_edge_fall ? 1'b0 : 1'b1);
    repeat (HALF - 1) @(negedge clk);
    b = ser_out;
    @(negedge clk);
  endtask

  task automatic frame();
    logic [15:0] w;
    logic b;
    if (model_level == 0) exp_q.push_back(16'h0000);
    else model_level--;
    for (int i = 0; i < 16; i++) begin
      period(i == 0, b);
      if (cfg_lsb_first) w[i] = b; else w[15-i] = b;
    end
    rx_word = w;
    ->word_ev;
    @(negedge clk);
  endtask

  // monitor: compares each received word with the scoreboard head
  always @(word_ev) begin
    logic [15:0] e;
    if (exp_q.size() == 0) begin
      chk(1'b0, cur_req, {16'h0, rx_word}, 32'hdead);
    end else begin
      e = exp_q.pop_front();
      chk(rx_word == e, cur_req, {16'h0, rx_word}, {16'h0, e});
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic b;
    logic s0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(fifo_level == 0, "R1", fifo_level, 0);
    chk(!full_flag && !underrun_flag && !ser_out, "R1", {full_flag, underrun_flag, ser_out}, 0);

    // R2 R4 R10: MSB first, rising edge, gp clock
    cur_req = "R2_R4";
    write32(32'h1234_ABCD);
    chk(fifo_level == 2, "R10", fifo_level, 2);
    frame();
    chk(fifo_level == 1, "R8", fifo_level, 1);
    frame();
    chk(fifo_level == 0, "R10", fifo_level, 0);
    // R8: no frame sync after the word gives idle zeros
    period(1'b0, b);
    chk(b == 1'b0, "R8", b, 0);
    period(1'b0, b);
    chk(b == 1'b0 && fifo_level == 0, "R8", {b, fifo_level}, 0);

    // R5 LSB first
    cur_req = "R5";
    cfg_lsb_first = 1'b1;
    write32(32'h8001_00F0);
    frame();
    frame();
    cfg_lsb_first = 1'b0;

    // R6 falling edge active
    cur_req = "R6";
    cfg_edge_fall = 1'b1;
    write32(32'hC3A5_5A3C);
    frame();
    frame();
    cfg_edge_fall = 1'b0;
    gp_clk = 1'b0;
    repeat (6) @(negedge clk);

    // R7 clock source: unselected line does nothing
    cur_req = "R7";
    cfg_clk_src = 1'b1;
    repeat (6) @(negedge clk);
    write32(32'h0F0F_F0F0);
    s0 = ser_out;
    use_rx = 1'b0;
    for (int i = 0; i < 4; i++) begin
      period(i == 0, b);
      chk(b == s0, "R7", b, s0);
    end
    chk(fifo_level == 2, "R7", fifo_level, 2);
    gp_clk = 1'b0;
    use_rx = 1'b1;
    frame();
    frame();
    rx_clk = 1'b0;
    use_rx = 1'b0;
    cfg_clk_src = 1'b0;
    repeat (6) @(negedge clk);

    // R3 fill to the limit, refusal at 30 and at 29
    cur_req = "R3";
    for (int i = 0; i < 15; i++) write32({16'hA000 + 16'(2*i+1), 16'hA000 + 16'(2*i)});
    chk(fifo_level == 30 && full_flag, "R3", {full_flag, fifo_level}, {1'b1, 5'd30});
    write32(32'hDEAD_BEEF);
    chk(fifo_level == 30, "R3", fifo_level, 30);
    frame();
    chk(fifo_level == 29 && full_flag, "R3", {full_flag, fifo_level}, {1'b1, 5'd29});
    write32(32'hBAD0_BAD1);
    chk(fifo_level == 29, "R3", fifo_level, 29);
    frame();
    chk(fifo_level == 28 && !full_flag, "R3", {full_flag, fifo_level}, {1'b0, 5'd28});
    write32(32'h5555_4444);
    chk(fifo_level == 30, "R3", fifo_level, 30);
    cur_req = "R2_R10";
    for (int i = 0; i < 30; i++) frame();
    chk(fifo_level == 0 && exp_q.size() == 0, "R10", fifo_level, 0);

    // R9 underrun
    cur_req = "R9";
    chk(!underrun_flag, "R9", underrun_flag, 0);
    frame();
    chk(underrun_flag, "R9", underrun_flag, 1);
    write32(32'hFFFF_FFFF);
    frame();
    frame();
    chk(underrun_flag, "R9", underrun_flag, 1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!underrun_flag && fifo_level == 0, "R1", {underrun_flag, fifo_level}, 0);

    finish_run();
  end

endmodule